// File: doc/BRIEF.md
# Boost Converter Supervisor and Mode Sequencer

This block supervises a multi-leg interleaved boost converter. It drives four controls: the gate-enable and synchronous-rectification controls of the PWM generator, a fast gate-kill line, and the back-to-back input disconnect relay. It sequences the converter through four phases: a start-up phase in which the relay closes and settles, normal running, a pause around each deliberate short-circuit of the fuel-cell source, and a latched shutdown when any protection flag trips.

While the converter runs, the block also chooses between synchronous switching and diode-like (non-synchronous) switching. On every control-loop iteration it reads the sign of the mode-boundary parameter. Synchronous switching is allowed only when a hold-off window has expired. That window is loaded at start-up and again on every set-point change, and it lasts a programmable number of loop iterations.

Top module: `boost_supervisor`

## Requirements
- R1: When any per-leg overcurrent flag or either overvoltage flag is high, `gate_kill` is 1 and `pwm_en` is 0 in that same cycle, with no clock edge in between.
- R2: A protection trip sets `faulted` to 1 at the next clock edge and opens the relay (`relay_closed` = 0). Both stay that way after the flags clear, until `rst_n` is asserted.
- R3: A `sc_pending` pulse during normal running drops `pwm_en` at the next edge. The relay stays closed for exactly RELAY_DLY cycles after that, then opens.
- R4: After the relay has opened for a short-circuit, it stays open until a `sc_done` pulse. It then closes at the next edge, and `pwm_en` returns RELAY_DLY cycles later with no further command.
- R5: On a cycle with `loop_tick` = 1, `k_neg` = 0 selects continuous conduction and `k_neg` = 1 selects discontinuous conduction. From the next cycle, `sync_en` is 1 only if continuous conduction was selected, the hold-off window has expired and `pwm_en` is 1.
- R6: After reset is released, the relay is closed and `pwm_en` is 0 for RELAY_DLY cycles. Switching then stays non-synchronous until `holdoff_iters` loop iterations have been counted in normal running.
- R7: A `setpt_chg` pulse reloads the hold-off window with `holdoff_iters`. `sync_en` is then 0 for the next `holdoff_iters` iterations, whatever the sign of `k_neg`.
- R8: While and right after `rst_n` is low, the outputs are: `pwm_en` = 0, `sync_en` = 0, `faulted` = 0 and `relay_closed` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the only way out of the fault state |
| leg_oc | input | NUM_LEGS | Overcurrent flag, one bit per leg |
| vin_ov | input | 1 | Input overvoltage flag |
| vout_ov | input | 1 | Output overvoltage flag |
| sc_pending | input | 1 | Pulse: source short-circuit about to start |
| sc_done | input | 1 | Pulse: source short-circuit interval over |
| setpt_chg | input | 1 | Pulse: current set-point changed |
| loop_tick | input | 1 | One-cycle strobe per control-loop iteration |
| k_neg | input | 1 | Sign of mode-boundary parameter, 1 = negative (valid with loop_tick) |
| holdoff_iters | input | HOLD_W | Length of the non-synchronous hold-off window in iterations |
| pwm_en | output | 1 | Gate drive enable for all legs |
| sync_en | output | 1 | High-side switch enable (synchronous mode) |
| gate_kill | output | 1 | Immediate gate shutdown request |
| relay_closed | output | 1 | Input disconnect relay command, 1 = closed |
| faulted | output | 1 | Latched protection fault |

## Verification
The bench builds the block with six legs, RELAY_DLY of 4 and an 8-bit hold-off width, and drives `holdoff_iters` with 3. This short settle delay makes every edge of the short-circuit pause reachable in a few cycles: gate-off, relay-open, relay-close and gate-on. A window of three iterations lets a single vector table show the window expiring, the sign of `k_neg` toggling synchronous mode, and a set-point change re-arming the window. Directed tests then cover trips on a single leg and on output overvoltage, the stickiness of the fault, and re-entry through reset.

// File: rtl/sup_pkg.sv
// Shared types for the converter supervisor.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package sup_pkg;
    typedef enum logic [2:0] {
        ST_CLOSE   = 3'd0,  // relay closed, gates off, settling
        ST_RUN     = 3'd1,  // normal switching
        ST_SC_OFF  = 3'd2,  // gates off ahead of relay opening
        ST_SC_OPEN = 3'd3,  // relay open during source short
        ST_FAULT   = 3'd4   // latched shutdown
    } sup_state_e;
endpackage

// File: rtl/sup_fault_or.sv
// Combines all protection flags into one trip line.
// Assumes: flags are already synchronous to clk and active high.
module sup_fault_or #(
    parameter int NUM_LEGS = 6
) (
    input  logic [NUM_LEGS-1:0] leg_oc,
    input  logic                vin_ov,
    input  logic                vout_ov,
    output logic                trip
);
    logic [NUM_LEGS:0] chain;

    assign chain[0] = vin_ov | vout_ov;

    // Build the per-leg OR chain
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        assign chain[g+1] = chain[g] | leg_oc[g];
    end

    assign trip = chain[NUM_LEGS];
endmodule

// File: rtl/sup_seq_fsm.sv
// Operating-state sequencer: start-up settle, run, short-circuit pause,
// sticky fault. Waits RELAY_DLY clocks between gate and relay actions.
// Assumes: RELAY_DLY >= 1; sc_pending/sc_done are single-cycle pulses.
module sup_seq_fsm
    import sup_pkg::*;
#(
    parameter int RELAY_DLY = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       trip,
    input  logic       sc_pending,
    input  logic       sc_done,
    output sup_state_e state
);
    localparam int DW = $clog2(RELAY_DLY + 1);
    localparam logic [DW-1:0] LAST = DW'(RELAY_DLY - 1);

    sup_state_e    nxt;
    logic [DW-1:0] cnt;
    logic          dly_done;

    assign dly_done = (cnt == LAST);

    // Next-state selection with trip taking priority
    always_comb begin
        nxt = state;
        unique case (state)
            ST_CLOSE:   if (dly_done)   nxt = ST_RUN;
            ST_RUN:     if (sc_pending) nxt = ST_SC_OFF;
            ST_SC_OFF:  if (dly_done)   nxt = ST_SC_OPEN;
            ST_SC_OPEN: if (sc_done)    nxt = ST_CLOSE;
            ST_FAULT:   nxt = ST_FAULT;
            default:    nxt = ST_FAULT;
        endcase
        if (trip) nxt = ST_FAULT;
    end

    // State register and settle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_CLOSE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (nxt != state) cnt <= '0;
            else if (state == ST_CLOSE || state == ST_SC_OFF) cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sup_holdoff.sv
// Non-synchronous hold-off window, counted in loop iterations.
// Assumes: load_val is stable around reset and reload strobes.
module sup_holdoff #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HOLD_W-1:0] load_val,
    input  logic              reload,
    input  logic              tick,
    output logic              expired
);
    logic [HOLD_W-1:0] remain;

    // Reload on reset or set-point change, count down per iteration
    always_ff @(posedge clk) begin
        if (!rst_n)                  remain <= load_val;
        else if (reload)             remain <= load_val;
        else if (tick && remain != 0) remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);
endmodule

// File: rtl/sup_mode_sel.sv
// Conduction-mode decision latched once per control-loop iteration.
// Assumes: k_neg is valid whenever loop_tick is high.
module sup_mode_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic loop_tick,
    input  logic k_neg,
    output logic ccm
);
    // Capture the mode sign on each iteration strobe
    always_ff @(posedge clk) begin
        if (!rst_n)         ccm <= 1'b0;
        else if (loop_tick) ccm <= ~k_neg;
    end
endmodule

// File: rtl/boost_supervisor.sv
// Top of the converter supervisor: protection OR, state sequencer,
// hold-off window and conduction-mode selection.
// Assumes: all inputs synchronous to clk; relay output is a level command.
module boost_supervisor
    import sup_pkg::*;
#(
    parameter int NUM_LEGS  = 6,
    parameter int RELAY_DLY = 4,
    parameter int HOLD_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LEGS-1:0] leg_oc,
    input  logic              vin_ov,
    input  logic              vout_ov,
    input  logic              sc_pending,
    input  logic              sc_done,
    input  logic              setpt_chg,
    input  logic              loop_tick,
    input  logic              k_neg,
    input  logic [HOLD_W-1:0] holdoff_iters,
    output logic              pwm_en,
    output logic              sync_en,
    output logic              gate_kill,
    output logic              relay_closed,
    output logic              faulted
);
    logic       trip;
    logic       ccm;
    logic       hold_done;
    sup_state_e state;

    sup_fault_or #(.NUM_LEGS(NUM_LEGS)) u_or (
        .leg_oc (leg_oc),
        .vin_ov (vin_ov),
        .vout_ov(vout_ov),
        .trip   (trip)
    );

    sup_seq_fsm #(.RELAY_DLY(RELAY_DLY)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .trip      (trip),
        .sc_pending(sc_pending),
        .sc_done   (sc_done),
        .state     (state)
    );

    sup_holdoff #(.HOLD_W(HOLD_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_val(holdoff_iters),
        .reload  (setpt_chg),
        .tick    (loop_tick && state == ST_RUN),
        .expired (hold_done)
    );

    sup_mode_sel u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .loop_tick(loop_tick),
        .k_neg    (k_neg),
        .ccm      (ccm)
    );

    // Output decode from state, live trip and mode
    always_comb begin
        gate_kill    = trip || state == ST_FAULT;
        pwm_en       = (state == ST_RUN) && !trip;
        sync_en      = pwm_en && ccm && hold_done;
        relay_closed = !(state == ST_SC_OPEN || state == ST_FAULT);
        faulted      = (state == ST_FAULT);
    end
endmodule

// File: rtl/sup_checker.sv
// Temporal checks on the supervisor ports, bound into the top module.
// Assumes: synchronous active-low reset on rst_n.
module sup_checker #(
    parameter int NUM_LEGS = 6,
    parameter int HOLD_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_LEGS-1:0] leg_oc,
    input logic              vin_ov,
    input logic              vout_ov,
    input logic              setpt_chg,
    input logic [HOLD_W-1:0] holdoff_iters,
    input logic              pwm_en,
    input logic              sync_en,
    input logic              gate_kill,
    input logic              relay_closed,
    input logic              faulted
);
    logic any_flag;
    assign any_flag = (|leg_oc) | vin_ov | vout_ov;

    AST_FLAG_KILLS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        any_flag |-> (gate_kill && !pwm_en)); // R1
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        faulted |=> faulted); // R2
    AST_FAULT_OPENS_RELAY: assert property (@(posedge clk) disable iff (!rst_n)
        faulted |-> !relay_closed); // R2
    AST_GATES_BEFORE_RELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(relay_closed) |-> (!pwm_en && $past(!pwm_en))); // R3
    AST_SYNC_NEEDS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        sync_en |-> pwm_en); // R5
    AST_SETPT_FORCES_ASYNC: assert property (@(posedge clk) disable iff (!rst_n)
        (setpt_chg && holdoff_iters != '0) |=> !sync_en); // R7
endmodule

bind boost_supervisor sup_checker #(.NUM_LEGS(NUM_LEGS), .HOLD_W(HOLD_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .leg_oc       (leg_oc),
    .vin_ov       (vin_ov),
    .vout_ov      (vout_ov),
    .setpt_chg    (setpt_chg),
    .holdoff_iters(holdoff_iters),
    .pwm_en       (pwm_en),
    .sync_en      (sync_en),
    .gate_kill    (gate_kill),
    .relay_closed (relay_closed),
    .faulted      (faulted)
);

// File: tb/boost_supervisor_tb_top.sv
module boost_supervisor_tb_top;
    localparam int NL = 6;
    localparam int DLY = 4;
    localparam int HW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NL-1:0] leg_oc = '0;
    logic          vin_ov = 1'b0, vout_ov = 1'b0;
    logic          sc_pending = 1'b0, sc_done = 1'b0, setpt_chg = 1'b0;
    logic          loop_tick = 1'b0, k_neg = 1'b0;
    logic [HW-1:0] holdoff_iters = 8'd3;
    logic          pwm_en, sync_en, gate_kill, relay_closed, faulted;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    boost_supervisor #(.NUM_LEGS(NL), .RELAY_DLY(DLY), .HOLD_W(HW)) dut_i (
        .clk(clk), .rst_n(rst_n), .leg_oc(leg_oc), .vin_ov(vin_ov),
        .vout_ov(vout_ov), .sc_pending(sc_pending), .sc_done(sc_done),
        .setpt_chg(setpt_chg), .loop_tick(loop_tick), .k_neg(k_neg),
        .holdoff_iters(holdoff_iters), .pwm_en(pwm_en), .sync_en(sync_en),
        .gate_kill(gate_kill), .relay_closed(relay_closed), .faulted(faulted)
    );

    // {k_neg, setpt_chg, expected sync_en}; hold-off window of 3 iterations
    localparam logic [2:0] VEC [10] = '{
        3'b000, 3'b000, 3'b001, 3'b100, 3'b001,
        3'b010, 3'b000, 3'b000, 3'b001, 3'b100
    };

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic iter(input logic kn, input logic sp);
        loop_tick = 1'b1; k_neg = kn; setpt_chg = sp;
        step(1);
        loop_tick = 1'b0; setpt_chg = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        // R8 reset state
        chk("R8 pwm_en", pwm_en, 1'b0);
        chk("R8 sync_en", sync_en, 1'b0);
        chk("R8 faulted", faulted, 1'b0);
        chk("R8 relay_closed", relay_closed, 1'b1);
        // R6 relay settle before gating
        step(DLY - 1);
        chk("R6 gates off during settle", pwm_en, 1'b0);
        step(1);
        chk("R6 gates on after settle", pwm_en, 1'b1);

        // R5 / R7 vector walk
        for (int v = 0; v < 10; v++) begin
            iter(VEC[v][2], VEC[v][1]);
            chk($sformatf("R5/R7 vector %0d sync_en", v), sync_en, VEC[v][0]);
        end

        // R3 short-circuit entry
        sc_pending = 1'b1;
        step(1);
        sc_pending = 1'b0;
        chk("R3 gates off at once", pwm_en, 1'b0);
        chk("R3 relay still closed", relay_closed, 1'b1);
        step(DLY - 1);
        chk("R3 relay closed through delay", relay_closed, 1'b1);
        step(1);
        chk("R3 relay opens", relay_closed, 1'b0);
        step(5);
        chk("R4 relay held open", relay_closed, 1'b0);
        // R4 automatic resume
        sc_done = 1'b1;
        step(1);
        sc_done = 1'b0;
        chk("R4 relay recloses", relay_closed, 1'b1);
        chk("R4 gates still off", pwm_en, 1'b0);
        step(DLY - 1);
        chk("R4 gates off during settle", pwm_en, 1'b0);
        step(1);
        chk("R4 gates back on", pwm_en, 1'b1);

        // R1 leg overcurrent acts without a clock edge
        leg_oc = 6'b000100;
        #1;
        chk("R1 gate_kill on leg flag", gate_kill, 1'b1);
        chk("R1 pwm_en off on leg flag", pwm_en, 1'b0);
        step(1);
        chk("R2 faulted latched", faulted, 1'b1);
        chk("R2 relay opened on fault", relay_closed, 1'b0);
        leg_oc = '0;
        step(5);
        chk("R2 fault sticky", faulted, 1'b1);
        chk("R2 gates stay off", pwm_en, 1'b0);

        // R8 reset leaves fault and restarts non-synchronous
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
        chk("R8 fault cleared", faulted, 1'b0);
        chk("R8 relay closed", relay_closed, 1'b1);
        step(DLY);
        chk("R6 running after restart", pwm_en, 1'b1);
        iter(1'b0, 1'b0);
        chk("R6 non-sync iteration 1", sync_en, 1'b0);
        iter(1'b0, 1'b0);
        chk("R6 non-sync iteration 2", sync_en, 1'b0);
        iter(1'b0, 1'b0);
        chk("R6 sync after window", sync_en, 1'b1);

        // R1 output overvoltage
        vout_ov = 1'b1;
        #1;
        chk("R1 pwm_en off on overvoltage", pwm_en, 1'b0);
        chk("R1 sync_en off on overvoltage", sync_en, 1'b0);
        step(1);
        vout_ov = 1'b0;
        chk("R2 faulted on overvoltage", faulted, 1'b1);

        finish_run();
    end
endmodule